// File: doc/BRIEF.md
# Pulse Record Word Streamer

This block sits between a FIFO of captured pulse records and a processor's 32-bit input port. Each record holds a count of the comparator thresholds a pulse crossed, followed by a 64-bit rise time and a 64-bit fall time for every threshold. The block pops one record at a time. It then hands the record to the processor as a series of 32-bit words, and the processor paces the transfer by toggling a single pump control level.

The processor raises pump to ask for the next word, reads `data_o`, and lowers pump to say that it has finished with the word. The block moves on to the next word only after pump has returned low. Only the thresholds that were actually crossed are sent, so a short pulse costs fewer transfers. A have-data flag marks a record that is in progress. A buffer-full flag mirrors the FIFO's full status, so that the processor can see when capture is stalled. A run input freezes the streamer while it is low.

Top module: `pulse_rec_streamer`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `data_o` is 0, `have_data_o` is 0, `buf_full_o` is 0 and `fifo_rd_o` is 0.
- R2: When the block is idle, `run_i` is 1 and `fifo_empty_i` is 0, `fifo_rd_o` pulses high for one cycle and the record on `fifo_rdata_i` is taken. `have_data_o` is high from the next cycle on. `fifo_rd_o` is never high while a record is in progress.
- R3: A rising edge of `pump_i` while a record is in progress (`pump_i` sampled 1 after being sampled 0) loads the next word onto `data_o` at that same clock edge. At no other time does `data_o` change.
- R4: After a word has been loaded, holding `pump_i` high never loads another word. The word index moves on only once `pump_i` is sampled low, so no word is skipped.
- R5: Record input layout: the crossed-threshold count is in bits [2:0]. The rise time of threshold t (0..5) is in bits [3+64t +: 64], and its fall time is in bits [3+64(6+t) +: 64]. Word 0 is a header whose value is the clamped count. Then, for each threshold in ascending order, four words follow: rise low half, rise high half, fall low half, fall high half.
- R6: A record with count n sends 1+4n words, with n clamped to 6, so at most 25 words are sent. A count of 0 sends only the header, and counts of 7 behave as 6.
- R7: `have_data_o` falls at the clock edge where `pump_i` is sampled low after the last word of the record.
- R8: `buf_full_o` equals `fifo_full_i` delayed by one clock.
- R9: While `run_i` is 0, no FIFO read occurs and `data_o` and `have_data_o` hold. A pump rising edge that occurs during the pause is discarded, so the processor must lower and raise pump again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = run, 0 = pause the streamer |
| pump_i | input | 1 | Processor pump level: rise = next word, fall = done with word |
| fifo_empty_i | input | 1 | FIFO holds no record |
| fifo_full_i | input | 1 | FIFO is full |
| fifo_rdata_i | input | 771 | Head record of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop strobe to the FIFO |
| data_o | output | 32 | Current streamed word |
| have_data_o | output | 1 | A record is being streamed |
| buf_full_o | output | 1 | Registered FIFO-full status |

## Verification
Every result of this block is due exactly one clock edge after its cause. A new `data_o` word appears at the edge that first sees `pump_i` high. `have_data_o` rises at the edge after the pop and falls at the edge that sees the final pump low. `buf_full_o` trails `fifo_full_i` by one edge. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the edge at which the result is due. Hold and pause checks read the same outputs again over several further cycles to confirm that nothing moved.

// File: rtl/pulse_rec_pkg.sv
`timescale 1ns/1ps
package pulse_rec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_WAIT_LO = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pulse_rec_pump_edge.sv
`timescale 1ns/1ps
module pulse_rec_pump_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pump_i,
  output logic rise_o,
  output logic high_o
);
  logic pump_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pump_q <= 1'b0;
    else         pump_q <= pump_i;
  end

  // previous level tracked even while paused, so edges seen in a pause are lost
  assign rise_o = pump_i & ~pump_q;
  assign high_o = pump_i;
endmodule

// File: rtl/pulse_rec_word_mux.sv
`timescale 1ns/1ps
module pulse_rec_word_mux #(
  parameter  int NUM_THR   = 6,
  parameter  int TIME_W    = 64,
  parameter  int WORD_W    = 32,
  localparam int CNT_W     = $clog2(NUM_THR + 1),
  localparam int HALVES    = TIME_W / WORD_W,
  localparam int WPT       = 2 * HALVES,
  localparam int NUM_WORDS = 1 + NUM_THR * WPT,
  localparam int IDX_W     = $clog2(NUM_WORDS),
  localparam int REC_W     = CNT_W + 2 * NUM_THR * TIME_W
) (
  input  logic [REC_W-1:0]  rec_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W-1:0]  cnt_raw;
  logic [CNT_W-1:0]  cnt_eff;
  logic [WORD_W-1:0] words [NUM_WORDS];

  assign cnt_raw  = rec_i[CNT_W-1:0];
  assign cnt_eff  = (cnt_raw > CNT_W'(NUM_THR)) ? CNT_W'(NUM_THR) : cnt_raw;
  assign words[0] = WORD_W'(cnt_eff);

  // word w>0: threshold-major, rise before fall, low half first
  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
    localparam int J    = w - 1;
    localparam int THR  = J / WPT;
    localparam int SUB  = J % WPT;
    localparam int EDGE = SUB / HALVES;
    localparam int HALF = SUB % HALVES;
    localparam int BASE = CNT_W + (EDGE * NUM_THR + THR) * TIME_W + HALF * WORD_W;
    assign words[w] = rec_i[BASE +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx_i == IDX_W'(i)) word_o = words[i];
    end
  end
endmodule

// File: rtl/pulse_rec_seq.sv
`timescale 1ns/1ps
module pulse_rec_seq
  import pulse_rec_pkg::*;
#(
  parameter  int NUM_THR   = 6,
  parameter  int WPT       = 4,
  localparam int CNT_W     = $clog2(NUM_THR + 1),
  localparam int NUM_WORDS = 1 + NUM_THR * WPT,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fifo_empty_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rise_i,
  input  logic             high_i,
  output logic             pop_o,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_eff;
  logic [IDX_W-1:0] last_d;

  assign cnt_eff = (cnt_i > CNT_W'(NUM_THR)) ? CNT_W'(NUM_THR) : cnt_i;
  assign last_d  = IDX_W'(cnt_eff) * IDX_W'(WPT);

  assign pop_o  = run_i && (state_q == ST_IDLE) && !fifo_empty_i;
  assign load_o = run_i && (state_q == ST_WAIT_HI) && rise_i;
  assign busy_o = (state_q != ST_IDLE);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else if (run_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!fifo_empty_i) begin
            idx_q   <= '0;
            last_q  <= last_d;
            state_q <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: begin
          if (rise_i) state_q <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          // index moves only once pump has really returned low
          if (!high_i) begin
            if (idx_q == last_q) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_WAIT_HI;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_rec_streamer.sv
`timescale 1ns/1ps
module pulse_rec_streamer #(
  parameter  int NUM_THR = 6,
  parameter  int TIME_W  = 64,
  parameter  int WORD_W  = 32,
  localparam int CNT_W   = $clog2(NUM_THR + 1),
  localparam int REC_W   = CNT_W + 2 * NUM_THR * TIME_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              pump_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  input  logic [REC_W-1:0]  fifo_rdata_i,
  output logic              fifo_rd_o,
  output logic [WORD_W-1:0] data_o,
  output logic              have_data_o,
  output logic              buf_full_o
);
  localparam int HALVES    = TIME_W / WORD_W;
  localparam int WPT       = 2 * HALVES;
  localparam int NUM_WORDS = 1 + NUM_THR * WPT;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  logic              rise, high, pop, load, busy;
  logic [IDX_W-1:0]  idx;
  logic [REC_W-1:0]  rec_q;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] data_q;
  logic              full_q;

  pulse_rec_pump_edge i_pump_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pump_i (pump_i),
    .rise_o (rise),
    .high_o (high)
  );

  pulse_rec_seq #(
    .NUM_THR (NUM_THR),
    .WPT     (WPT)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .fifo_empty_i (fifo_empty_i),
    .cnt_i        (fifo_rdata_i[CNT_W-1:0]),
    .rise_i       (rise),
    .high_i       (high),
    .pop_o        (pop),
    .load_o       (load),
    .busy_o       (busy),
    .idx_o        (idx)
  );

  pulse_rec_word_mux #(
    .NUM_THR (NUM_THR),
    .TIME_W  (TIME_W),
    .WORD_W  (WORD_W)
  ) i_word_mux (
    .rec_i  (rec_q),
    .idx_i  (idx),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q  <= '0;
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= fifo_full_i;
      if (pop)  rec_q  <= fifo_rdata_i;
      if (load) data_q <= word;
    end
  end

  assign fifo_rd_o   = pop;
  assign data_o      = data_q;
  assign have_data_o = busy;
  assign buf_full_o  = full_q;
endmodule

// File: rtl/pulse_rec_streamer_chk.sv
`timescale 1ns/1ps
module pulse_rec_streamer_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              pump_i,
  input logic              fifo_empty_i,
  input logic              fifo_full_i,
  input logic              fifo_rd_o,
  input logic [WORD_W-1:0] data_o,
  input logic              have_data_o,
  input logic              buf_full_o
);
  a_r2_pop_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> (!have_data_o && run_i && !fifo_empty_i));

  a_r2_busy_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> have_data_o);

  a_r3_data_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> ($past(pump_i) && !$past(pump_i, 2) && $past(run_i) && $past(have_data_o)));

  a_r7_drop_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(have_data_o) |-> (!$past(pump_i) && $past(run_i)));

  a_r8_full_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |=> buf_full_o);

  a_r8_full_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_full_i |=> !buf_full_o);

  a_r9_pause_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !fifo_rd_o);

  a_r9_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(data_o) && $stable(have_data_o)));
endmodule

bind pulse_rec_streamer pulse_rec_streamer_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .pump_i       (pump_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_rd_o    (fifo_rd_o),
  .data_o       (data_o),
  .have_data_o  (have_data_o),
  .buf_full_o   (buf_full_o)
);

// File: tb/test_pulse_rec_streamer.sv
`timescale 1ns/1ps
module test_pulse_rec_streamer;
  localparam int NT    = 6;
  localparam int REC_W = 3 + 2 * NT * 64;
  localparam int DEPTH = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run = 1'b0;
  logic              pump = 1'b0;
  logic              fifo_empty, fifo_full, fifo_rd;
  logic [REC_W-1:0]  fifo_rdata;
  logic [31:0]       data;
  logic              have_data, buf_full;

  logic [REC_W-1:0]  rec_mem [DEPTH];
  int wr_n = 0, rd_n = 0, strm_n = 0;
  int checks = 0, errors = 0;
  logic rd_seen;

  always #2 clk = ~clk;

  assign fifo_empty = (wr_n == rd_n);
  assign fifo_full  = (wr_n - rd_n) == DEPTH;
  assign fifo_rdata = rec_mem[rd_n % DEPTH];

  pulse_rec_streamer i_pulse_rec_streamer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .run_i        (run),
    .pump_i       (pump),
    .fifo_empty_i (fifo_empty),
    .fifo_full_i  (fifo_full),
    .fifo_rdata_i (fifo_rdata),
    .fifo_rd_o    (fifo_rd),
    .data_o       (data),
    .have_data_o  (have_data),
    .buf_full_o   (buf_full)
  );

  // FIFO pop model: strobe seen mid-cycle, pointer moves just after the edge
  initial begin
    forever begin
      @(negedge clk);
      rd_seen = fifo_rd;
      @(posedge clk);
      #0.5;
      if (rd_seen) rd_n++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clamp_n(logic [2:0] c);
    return (c > 3'd6) ? 6 : int'(c);
  endfunction

  function automatic logic [REC_W-1:0] mk_rec(int n);
    logic [REC_W-1:0] r = '0;
    r[2:0] = 3'(n);
    for (int t = 0; t < NT; t++) begin
      r[3 + t*64 +: 64]      = {$urandom, $urandom};
      r[3 + (NT+t)*64 +: 64] = {$urandom, $urandom};
    end
    return r;
  endfunction

  // R5 word order
  function automatic logic [31:0] exp_word(logic [REC_W-1:0] r, int k);
    int j, t, s, base;
    if (k == 0) return 32'(clamp_n(r[2:0]));
    j = k - 1; t = j / 4; s = j % 4;
    base = 3 + ((s >= 2) ? (NT + t) : t) * 64 + (s % 2) * 32;
    return r[base +: 32];
  endfunction

  task automatic push(logic [REC_W-1:0] r);
    rec_mem[wr_n % DEPTH] = r;
    wr_n++;
  endtask

  task automatic wait_have();
    int g = 0;
    while (!have_data && g < 20) begin step(1); g++; end
    check("R2 have_data after pop", 32'(have_data), 32'd1);
  endtask

  task automatic pump_word(logic [31:0] exp, int hold);
    pump = 1'b1;
    step(1);
    check("R3/R5 word on pump rise", data, exp);
    if (hold > 0) begin
      step(hold);
      check("R4 no advance while pump high", data, exp);
    end
    pump = 1'b0;
    step(1);
  endtask

  task automatic stream_next(int hold_at);
    logic [REC_W-1:0] r = rec_mem[strm_n % DEPTH];
    int nw = 1 + 4 * clamp_n(r[2:0]);
    strm_n++;
    wait_have();
    for (int k = 0; k < nw; k++) begin
      pump_word(exp_word(r, k), (k == hold_at) ? 4 : 0);
      if (k < nw - 1) check("R6 have_data held mid record", 32'(have_data), 32'd1);
    end
    check("R6/R7 have_data drops after last word", 32'(have_data), 32'd0);
  endtask

  initial begin
    logic [REC_W-1:0] r;
    int s;
    s = $urandom(32'h0051_7eed);
    // R1
    step(3);
    check("R1 have_data in reset", 32'(have_data), 32'd0);
    check("R1 data in reset", data, 32'd0);
    check("R1 buf_full in reset", 32'(buf_full), 32'd0);
    check("R1 fifo_rd in reset", 32'(fifo_rd), 32'd0);
    rst_n = 1'b1;
    step(1);
    check("R1 have_data after reset", 32'(have_data), 32'd0);
    check("R1 data after reset", data, 32'd0);
    run = 1'b1;
    step(2);

    // full six-threshold record, hold check on word 1 (R4)
    push(mk_rec(6));
    stream_next(1);
    check("R2 single pop", 32'(rd_n), 32'd1);
    // header only (R6)
    push(mk_rec(0));
    stream_next(-1);
    // count 7 clamps to six (R6)
    push(mk_rec(7));
    stream_next(-1);

    // R9 pause mid record
    r = mk_rec(2);
    push(r);
    strm_n++;
    wait_have();
    pump_word(exp_word(r, 0), 0);
    run = 1'b0;
    pump = 1'b1;
    step(2);
    check("R9 pump ignored while paused", data, exp_word(r, 0));
    run = 1'b1;
    step(2);
    check("R9 paused edge discarded", data, exp_word(r, 0));
    pump = 1'b0;
    step(1);
    for (int k = 1; k < 9; k++) pump_word(exp_word(r, k), 0);
    check("R7 have_data drop after pause", 32'(have_data), 32'd0);

    // R8 fill while paused
    run = 1'b0;
    step(1);
    for (int i = 0; i < DEPTH; i++) begin
      push(mk_rec($urandom_range(0, 7)));
      step(1);
      if (i == DEPTH - 2) check("R8 not full at 15", 32'(buf_full), 32'd0);
    end
    check("R8 buf_full one cycle after full", 32'(buf_full), 32'd1);
    check("R9 no pop while paused", 32'(rd_n), 32'(strm_n));
    run = 1'b1;
    step(2);
    check("R8 buf_full clears after pop", 32'(buf_full), 32'd0);
    for (int i = 0; i < DEPTH; i++) stream_next($urandom_range(0, 3) == 0 ? 0 : -1);

    // random mix
    for (int i = 0; i < 20; i++) begin
      push(mk_rec($urandom_range(0, 7)));
      if ($urandom_range(0, 1) == 1) push(mk_rec($urandom_range(0, 7)));
      while (strm_n < wr_n) stream_next($urandom_range(0, 4) == 0 ? 2 : -1);
    end
    check("R2 all records popped", 32'(rd_n), 32'(wr_n));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule